// File: doc/BRIEF.md
# Eight-Bit Multi-Function ALU

This block is a purely combinational arithmetic logic unit for an 8-bit datapath. It accepts two operands and a 3-bit operation code. It returns one result byte, a carry/borrow flag and a zero flag.

Every function is evaluated at the same time from the same operands: bitwise logic, a ripple add/subtract chain, a left barrel shift and an unsigned array multiplier. An 8-way selector then chooses which result reaches the output. The 16-bit product is never returned whole. Two neighbouring opcodes each expose one byte of it, so a sequencer that holds the operands steady and issues both codes collects the full product. The block holds no state, so the surrounding pipeline decides where its inputs and outputs are registered.

Top module: `alu8_top`

## Requirements
- R1: Opcode 3'b000 returns the bitwise NAND of a_i and b_i.
- R2: Opcode 3'b001 returns the bitwise NOR of a_i and b_i.
- R3: Opcode 3'b010 returns the bitwise XOR of a_i and b_i.
- R4: Opcode 3'b101 returns (a_i + b_i) mod 256. For this opcode, carry_o is the carry out of bit 7.
- R5: Opcode 3'b011 returns (a_i - b_i) mod 256, formed as a_i + ~b_i + 1. For this opcode, carry_o is a borrow flag that is 1 exactly when a_i < b_i as unsigned values.
- R6: Opcode 3'b100 shifts a_i left by b_i[2:0] and fills the vacated positions with zeros. A shift amount of 0 passes a_i through unchanged. Bits b_i[7:3] have no effect on the result.
- R7: Opcode 3'b110 returns bits 7..0 of the unsigned 16-bit product a_i * b_i.
- R8: Opcode 3'b111 returns bits 15..8 of the same unsigned product, so issuing 3'b110 and then 3'b111 with the same operands yields the complete product.
- R9: For every opcode other than 3'b011 and 3'b101, carry_o is 0.
- R10: zero_o is 1 exactly when result_o is 8'h00, for every opcode.
- R11: The block has no clock or reset. All outputs depend only on the present a_i, b_i and op_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand; also the value that is shifted |
| b_i | input | 8 | Second operand; its bits [2:0] give the shift amount |
| op_i | input | 3 | Operation code |
| result_o | output | 8 | Selected result byte |
| carry_o | output | 1 | Carry for add, borrow for subtract, 0 otherwise |
| zero_o | output | 1 | 1 when result_o is all zeros |

## Verification
Every output, including both product bytes, is valid in the same cycle that a_i, b_i and op_i change, with no register in any path. The bench therefore changes the inputs on a falling clock edge and reads the outputs on the next rising edge. This gives the longest ripple chain, which runs through the multiplier rows, half a period to settle. For each operand pair, all eight opcodes are applied back to back. This shows that the two product bytes come from one product and that carry_o is forced to 0 when a non-arithmetic opcode follows an arithmetic one.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_NAND  = 3'b000,
    OP_NOR   = 3'b001,
    OP_XOR   = 3'b010,
    OP_SUB   = 3'b011,
    OP_SHL   = 3'b100,
    OP_ADD   = 3'b101,
    OP_MUL_L = 3'b110,
    OP_MUL_H = 3'b111
  } alu_op_e;

  localparam int unsigned ALU_W = 8;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] nand_o,
  output logic [W-1:0] nor_o,
  output logic [W-1:0] xor_o
);
  genvar g;
  generate
    for (g = 0; g < int'(W); g++) begin : g_bit
      assign nand_o[g] = ~(a_i[g] & b_i[g]);
      assign nor_o[g]  = ~(a_i[g] | b_i[g]);
      assign xor_o[g]  = a_i[g] ^ b_i[g];
    end
  endgenerate

  // a NOR bit set implies both inputs low, so NAND must be set there too
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_nor_implies_nand_R2: assert ((nor_o & ~nand_o) == '0);
      // xor is one exactly where nand is set and nor is clear
      assert_xor_partition_R3: assert (xor_o == (nand_o & ~nor_o));
    end
  end
endmodule

// File: rtl/alu_ripple_addsub.sv
module alu_ripple_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0]   c;
  logic [W-1:0] b_eff;

  assign c[0] = sub_i;

  genvar g;
  generate
    for (g = 0; g < int'(W); g++) begin : g_slice
      logic p;
      assign b_eff[g]  = b_i[g] ^ sub_i;
      assign p         = a_i[g] ^ b_eff[g];
      assign sum_o[g]  = p ^ c[g];
      assign c[g+1]    = (a_i[g] & b_eff[g]) | (p & c[g]);
    end
  endgenerate

  assign cout_o = c[W];

  always_comb begin
    if (!$isunknown({a_i, b_i, sub_i})) begin
      assert_ripple_arith_R4: assert ({cout_o, sum_o} ==
        ({1'b0, a_i} + {1'b0, (sub_i ? ~b_i : b_i)} + (W+1)'(sub_i)));
      // subtract: carry-out low exactly when a < b
      assert_sub_borrow_R5: assert (!sub_i || (cout_o == (a_i >= b_i)));
    end
  end
endmodule

// File: rtl/alu_barrel_shl.sv
module alu_barrel_shl #(
  parameter int unsigned W   = 8,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0]   a_i,
  input  logic [SHW-1:0] amt_i,
  output logic [W-1:0]   res_o
);
  logic [W-1:0] stage [SHW+1];

  assign stage[0] = a_i;

  genvar k;
  generate
    for (k = 0; k < int'(SHW); k++) begin : g_stage
      assign stage[k+1] = amt_i[k] ? (stage[k] << (1 << k)) : stage[k];
    end
  endgenerate

  assign res_o = stage[SHW];

  always_comb begin
    if (!$isunknown({a_i, amt_i})) begin
      assert_shift_zero_fill_R6: assert ((res_o & ((W'(1) << amt_i) - W'(1))) == '0);
      assert_shift_pass_R6: assert ((amt_i != '0) || (res_o == a_i));
    end
  end
endmodule

// File: rtl/alu_array_mult.sv
module alu_array_mult #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  // acc[i] holds the upper W bits of the running sum before row i
  logic [W-1:0] acc [W+1];
  logic [W-1:0] low;

  assign acc[0] = '0;

  genvar r;
  generate
    for (r = 0; r < int'(W); r++) begin : g_row
      logic [W-1:0] pp;
      logic [W-1:0] s;
      logic         co;
      assign pp = b_i[r] ? a_i : '0;
      alu_ripple_addsub #(.W(W)) u_row (
        .a_i   (acc[r]),
        .b_i   (pp),
        .sub_i (1'b0),
        .sum_o (s),
        .cout_o(co)
      );
      assign low[r]   = s[0];
      assign acc[r+1] = {co, s[W-1:1]};
    end
  endgenerate

  assign prod_o = {acc[W], low};

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      assert_product_R7: assert (prod_o == ((2*W)'(a_i) * (2*W)'(b_i)));
    end
  end
endmodule

// File: rtl/alu8_top.sv
module alu8_top
  import alu8_pkg::*;
#(
  parameter int unsigned W = ALU_W,
  localparam int unsigned SHW = $clog2(W)
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         carry_o,
  output logic         zero_o
);
  logic [W-1:0]   nand_r, nor_r, xor_r;
  logic [W-1:0]   as_sum;
  logic           as_cout;
  logic [W-1:0]   shl_r;
  logic [2*W-1:0] prod;
  logic           is_sub;
  alu_op_e        op;

  assign op     = alu_op_e'(op_i);
  assign is_sub = (op == OP_SUB);

  alu_logic_unit #(.W(W)) u_logic (
    .a_i   (a_i),
    .b_i   (b_i),
    .nand_o(nand_r),
    .nor_o (nor_r),
    .xor_o (xor_r)
  );

  alu_ripple_addsub #(.W(W)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (is_sub),
    .sum_o (as_sum),
    .cout_o(as_cout)
  );

  alu_barrel_shl #(.W(W)) u_shl (
    .a_i  (a_i),
    .amt_i(b_i[SHW-1:0]),
    .res_o(shl_r)
  );

  alu_array_mult #(.W(W)) u_mult (
    .a_i   (a_i),
    .b_i   (b_i),
    .prod_o(prod)
  );

  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    unique case (op)
      OP_NAND:  result_o = nand_r;
      OP_NOR:   result_o = nor_r;
      OP_XOR:   result_o = xor_r;
      OP_SUB:   begin result_o = as_sum; carry_o = ~as_cout; end
      OP_SHL:   result_o = shl_r;
      OP_ADD:   begin result_o = as_sum; carry_o = as_cout; end
      OP_MUL_L: result_o = prod[W-1:0];
      OP_MUL_H: result_o = prod[2*W-1:W];
      default:  result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i})) begin
      assert_carry_gated_R9: assert ((op == OP_ADD) || (op == OP_SUB) || !carry_o);
      assert_xor_zero_R10: assert ((op != OP_XOR) || (zero_o == (a_i == b_i)));
      assert_sub_zero_R10: assert ((op != OP_SUB) || (zero_o == (a_i == b_i)));
      assert_high_byte_R8: assert ((op != OP_MUL_H) ||
        (result_o == W'(((2*W)'(a_i) * (2*W)'(b_i)) >> W)));
    end
  end
endmodule

// File: tb/alu8_top_tb_top.sv
module alu8_top_tb_top;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [2:0] op;
  logic [7:0] res;
  logic       cy, zf;
  int         n_chk  = 0;
  int         n_fail = 0;
  bit         done   = 1'b0;

  always #5 clk = ~clk;

  alu8_top dut_i (
    .a_i     (a),
    .b_i     (b),
    .op_i    (op),
    .result_o(res),
    .carry_o (cy),
    .zero_o  (zf)
  );

  function automatic logic [7:0] exp_res(logic [7:0] x, logic [7:0] y, logic [2:0] o);
    logic [15:0] p;
    p = 16'(x) * 16'(y);
    case (o)
      3'b000:  return ~(x & y);          // R1
      3'b001:  return ~(x | y);          // R2
      3'b010:  return x ^ y;             // R3
      3'b011:  return 8'(x - y);         // R5
      3'b100:  return 8'(x << y[2:0]);   // R6
      3'b101:  return 8'(x + y);         // R4
      3'b110:  return p[7:0];            // R7
      default: return p[15:8];           // R8
    endcase
  endfunction

  function automatic logic exp_cy(logic [7:0] x, logic [7:0] y, logic [2:0] o);
    logic [8:0] s;
    s = 9'(x) + 9'(y);
    if (o == 3'b101) return s[8];        // R4
    if (o == 3'b011) return (x < y);     // R5
    return 1'b0;                         // R9
  endfunction

  function automatic string req_of(logic [2:0] o);
    case (o)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b010:  return "R3";
      3'b011:  return "R5";
      3'b100:  return "R6";
      3'b101:  return "R4";
      3'b110:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string rq, logic [15:0] act, logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s a=%02h b=%02h op=%0d act=%0h exp=%0h", rq, a, b, op, act, expv);
    end
  endtask

  task automatic run(logic [7:0] x, logic [7:0] y, logic [2:0] o);
    logic [7:0] er;
    @(negedge clk);
    a = x; b = y; op = o;
    @(posedge clk);
    er = exp_res(x, y, o);
    chk(req_of(o), 16'(res), 16'(er));
    chk((o == 3'b011 || o == 3'b101) ? req_of(o) : "R9", 16'(cy), 16'(exp_cy(x, y, o)));
    chk("R10", 16'(zf), 16'(er == 8'h00));
  endtask

  task automatic all_ops(logic [7:0] x, logic [7:0] y);
    for (int o = 0; o < 8; o++) run(x, y, 3'(o));
  endtask

  initial begin
    logic [7:0] lo, hi, c_lo, c_hi;
    logic [7:0] corner [5];
    int unsigned seed;
    corner = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'h7F};
    a = '0; b = '0; op = '0;
    // R11: no reset exists; outputs follow inputs in the same cycle
    @(posedge clk);
    chk("R11", 16'(res), 16'hFF);
    chk("R11", 16'(zf), 16'h0);

    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        all_ops(corner[i], corner[j]);

    // R6: upper shift-amount bits ignored, zero shift passes through
    run(8'hB5, 8'h03, 3'b100); c_lo = res;
    run(8'hB5, 8'hFB, 3'b100); chk("R6", 16'(res), 16'(c_lo));
    run(8'hC3, 8'hF8, 3'b100); chk("R6", 16'(res), 16'hC3);

    // R8: two reads with held operands rebuild the full product
    run(8'hFF, 8'hFF, 3'b110); lo = res;
    run(8'hFF, 8'hFF, 3'b111); hi = res;
    chk("R8", {hi, lo}, 16'hFE01);

    // R9: carry cleared when a non-arith op follows an add with carry
    run(8'hF0, 8'h20, 3'b101); chk("R4", 16'(cy), 16'h1);
    run(8'hF0, 8'h20, 3'b010); chk("R9", 16'(cy), 16'h0);

    seed = 32'd1234;
    void'($urandom(seed));
    for (int k = 0; k < 1200; k++) begin
      c_lo = 8'($urandom());
      c_hi = 8'($urandom());
      all_ops(c_lo, c_hi);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R11 watchdog act=timeout exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule